// File: doc/BRIEF.md
# Nine-Bit Serial Port

This block is an asynchronous serial transmitter and receiver run from one byte-wide control and status register. Software picks an 8-bit or 9-bit data frame, enables the receiver and, if needed, an address-filter mode for multidrop links in which the ninth bit marks an address frame. Software supplies the ninth transmit bit. Hardware captures the ninth received bit, or the stop bit in 8-bit mode.

Bit timing comes from an external tick at sixteen times the bit rate. The receiver confirms a start bit at its midpoint and samples every later bit at its centre. Two flags show that a frame has been sent and that a frame has been received. Hardware sets each flag and it stays set until software writes it clear. The interrupt output is high while either flag is set.

Top module: `ninebit_uart`

## Requirements
- R1: The control byte has these fields: bit 7 frame select (1 = 8-bit frame, 0 = 9-bit frame), bit 5 address-filter enable, bit 4 receive enable, bit 3 ninth transmit bit, bit 2 ninth received bit, bit 1 transmit-done flag, bit 0 receive-done flag. A register write loads every field from the written byte. Bit 6 always reads 0. Reset clears the whole byte.
- R2: Each frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts 16 baud ticks. In 9-bit mode, bit 3 of the control byte is sent after the eighth data bit.
- R3: In 8-bit mode the stop bit follows the eighth data bit directly. No ninth bit is sent.
- R4: The transmit-done flag sets when the stop bit ends. It stays set until a register write loads a 0 into it.
- R5: A transmit-data write made while a frame is being sent is ignored. The frame in progress is not altered and no second frame follows it.
- R6: While receive enable is 1, a received frame loads the receive-data output and sets the receive-done flag. The flag stays set until a write clears it. A frame that starts while receive enable is 0 leaves the flag and the data unchanged.
- R7: In 9-bit mode, bit 2 of the control byte takes the ninth received bit.
- R8: In 8-bit mode with the address filter off, bit 2 takes the sampled stop bit, so a stop bit of 0 gives 0.
- R9: In 9-bit mode with the address filter on, a frame whose ninth bit is 0 leaves the data, bit 2 and the receive-done flag unchanged. A frame whose ninth bit is 1 is accepted.
- R10: A low pulse on the receive pin that ends before the middle of a start bit is rejected. A valid frame sent after it is received correctly.
- R11: The interrupt output equals the OR of the transmit-done and receive-done flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| regWrEn | input | 1 | Control byte write strobe |
| regWrData | input | 8 | Control byte write value |
| ctrlOut | output | 8 | Control and status byte readback |
| txDataWrEn | input | 1 | Transmit data write strobe; starts a frame when idle |
| txDataIn | input | 8 | Transmit data byte |
| rxDataOut | output | 8 | Last accepted received byte |
| rxPin | input | 1 | Serial receive line |
| txPin | output | 1 | Serial transmit line, idles high |
| irq | output | 1 | Interrupt, high while either flag is set |

## Verification
The transmitter is driven with bytes of alternating, sparse and edge-heavy patterns such as 0xA5, 0x3C, 0x81 and 0x55. Sending each in both frame sizes, with the ninth bit at 1 and at 0, shows whether the bit order is right, whether a bit is dropped or repeated, and whether the ninth bit is inserted. The receiver is sent frames that differ in the ninth bit, in the stop bit value and in the enable and filter settings. Each result therefore shows which rule decided whether the frame was accepted and where bit 2 got its value. A short start glitch followed by a good frame separates proper start validation from acceptance on the first low sample.

// File: rtl/nineuart_pkg.sv
package nineuart_pkg;

  localparam int unsigned DATA_W  = 8;
  // start + eight data + optional ninth + stop
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);

  // control byte field positions (software decodes these)
  localparam int unsigned CTL_FRAME8 = 7;
  localparam int unsigned CTL_SPARE  = 6;
  localparam int unsigned CTL_MPEN   = 5;
  localparam int unsigned CTL_RXEN   = 4;
  localparam int unsigned CTL_TXB9   = 3;
  localparam int unsigned CTL_RXB9   = 2;
  localparam int unsigned CTL_TXDONE = 1;
  localparam int unsigned CTL_RXDONE = 0;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  typedef struct packed {
    logic             loadTx;
    logic             shiftTx;
    logic             setTxDone;
    logic             rxCapture;
    logic [IDX_W-1:0] rxBitIdx;
    logic             rxCommit;
    logic             rxNine;
  } strobe_t;

endpackage

// File: rtl/nineuart_ctrl.sv
module nineuart_ctrl
  import nineuart_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    baudTick,
  input  logic    txStart,
  input  logic    rxLine,
  input  logic    frame8,
  input  logic    rxEn,
  output strobe_t stb
);

  localparam int unsigned CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] LAST8     = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST9     = IDX_W'(DATA_W + 2);
  localparam logic [IDX_W-1:0] DATA_LAST8 = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] DATA_LAST9 = IDX_W'(DATA_W);

  // ---------------- transmit sequencer ----------------
  logic             txBusy;
  logic [CNT_W-1:0] txTick;
  logic [IDX_W-1:0] txIdx;
  logic [IDX_W-1:0] txLastIdx;
  logic             txBitEnd;

  assign txBitEnd = txBusy && baudTick && (txTick == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy    <= 1'b0;
      txTick    <= '0;
      txIdx     <= '0;
      txLastIdx <= '0;
    end else if (!txBusy) begin
      if (txStart) begin
        txBusy    <= 1'b1;
        txTick    <= '0;
        txIdx     <= '0;
        txLastIdx <= frame8 ? LAST8 : LAST9;
      end
    end else if (baudTick) begin
      if (txTick == LAST_TICK) begin
        txTick <= '0;
        txIdx  <= txIdx + 1'b1;
        if (txIdx == txLastIdx) begin
          txBusy <= 1'b0;
        end
      end else begin
        txTick <= txTick + 1'b1;
      end
    end
  end

  // ---------------- receive sequencer ----------------
  rxState_t         rxState;
  logic [CNT_W-1:0] rxTick;
  logic [IDX_W-1:0] rxIdx;
  logic             rxNine;
  logic             rxLastTick;
  logic [IDX_W-1:0] rxDataLast;

  assign rxLastTick = baudTick && (rxTick == LAST_TICK);
  assign rxDataLast = rxNine ? DATA_LAST9 : DATA_LAST8;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxIdx   <= '0;
      rxNine  <= 1'b0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (baudTick && rxEn && !rxLine) begin
            rxState <= RX_START;
            rxTick  <= '0;
          end
        end
        RX_START: begin
          if (baudTick) begin
            if (rxTick == MID_TICK) begin
              rxTick <= '0;
              rxIdx  <= '0;
              rxNine <= !frame8;
              rxState <= rxLine ? RX_IDLE : RX_DATA;
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (baudTick) begin
            if (rxTick == LAST_TICK) begin
              rxTick <= '0;
              rxIdx  <= rxIdx + 1'b1;
              if (rxIdx == rxDataLast) begin
                rxState <= RX_STOP;
              end
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (baudTick) begin
            if (rxTick == LAST_TICK) begin
              rxTick  <= '0;
              rxState <= RX_IDLE;
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // ---------------- strobes to the datapath ----------------
  always_comb begin
    stb.loadTx    = txStart && !txBusy;
    stb.shiftTx   = txBitEnd;
    stb.setTxDone = txBitEnd && (txIdx == txLastIdx);
    stb.rxCapture = (rxState == RX_DATA) && rxLastTick;
    stb.rxBitIdx  = rxIdx;
    stb.rxCommit  = (rxState == RX_STOP) && rxLastTick;
    stb.rxNine    = rxNine;
  end

endmodule

// File: rtl/nineuart_dp.sv
module nineuart_dp
  import nineuart_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxPin,
  output logic [7:0]        ctrlByte,
  output logic [DATA_W-1:0] rxData,
  output logic              txPin,
  output logic              rxLine,
  output logic              frame8,
  output logic              rxEn,
  output logic              txDone,
  output logic              rxDone
);

  // control fields
  logic frame8Q, mpEnQ, rxEnQ, txBit9Q, rxBit9Q, txDoneQ, rxDoneQ;

  // receive line synchroniser, idles high
  logic rxMeta, rxSyncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxSyncQ <= 1'b1;
    end else begin
      rxMeta  <= rxPin;
      rxSyncQ <= rxMeta;
    end
  end

  assign rxLine = rxSyncQ;

  // transmit shift register: all ones when idle, so txPin idles high
  logic [FRAME_W-1:0] txShift;
  logic               ninthOut;

  assign ninthOut = frame8Q ? 1'b1 : txBit9Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (stb.loadTx) begin
      txShift <= {1'b1, ninthOut, txData, 1'b0};
    end else if (stb.shiftTx) begin
      txShift <= {1'b1, txShift[FRAME_W-1:1]};
    end
  end

  assign txPin = txShift[0];

  // receive bit collection
  logic [DATA_W:0] rxBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBits <= '0;
    end else if (stb.rxCapture) begin
      rxBits[stb.rxBitIdx] <= rxSyncQ;
    end
  end

  // acceptance: the address filter only acts on 9-bit frames
  logic rxAccept;
  logic rxBit9Next;

  always_comb begin
    if (stb.rxNine) begin
      rxAccept   = !mpEnQ || rxBits[DATA_W];
      rxBit9Next = rxBits[DATA_W];
    end else begin
      rxAccept   = 1'b1;
      rxBit9Next = mpEnQ ? rxBit9Q : rxSyncQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (stb.rxCommit && rxAccept) begin
      rxData <= rxBits[DATA_W-1:0];
    end
  end

  // control byte: software load, hardware events take priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame8Q <= 1'b0;
      mpEnQ   <= 1'b0;
      rxEnQ   <= 1'b0;
      txBit9Q <= 1'b0;
      rxBit9Q <= 1'b0;
      txDoneQ <= 1'b0;
      rxDoneQ <= 1'b0;
    end else begin
      if (regWrEn) begin
        frame8Q <= regWrData[CTL_FRAME8];
        mpEnQ   <= regWrData[CTL_MPEN];
        rxEnQ   <= regWrData[CTL_RXEN];
        txBit9Q <= regWrData[CTL_TXB9];
        rxBit9Q <= regWrData[CTL_RXB9];
        txDoneQ <= regWrData[CTL_TXDONE];
        rxDoneQ <= regWrData[CTL_RXDONE];
      end
      if (stb.setTxDone) begin
        txDoneQ <= 1'b1;
      end
      if (stb.rxCommit && rxAccept) begin
        rxDoneQ <= 1'b1;
        rxBit9Q <= rxBit9Next;
      end
    end
  end

  always_comb begin
    ctrlByte             = '0;
    ctrlByte[CTL_FRAME8] = frame8Q;
    ctrlByte[CTL_SPARE]  = 1'b0;
    ctrlByte[CTL_MPEN]   = mpEnQ;
    ctrlByte[CTL_RXEN]   = rxEnQ;
    ctrlByte[CTL_TXB9]   = txBit9Q;
    ctrlByte[CTL_RXB9]   = rxBit9Q;
    ctrlByte[CTL_TXDONE] = txDoneQ;
    ctrlByte[CTL_RXDONE] = rxDoneQ;
  end

  assign frame8 = frame8Q;
  assign rxEn   = rxEnQ;
  assign txDone = txDoneQ;
  assign rxDone = rxDoneQ;

endmodule

// File: rtl/ninebit_uart.sv
module ninebit_uart
  import nineuart_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] ctrlOut,
  input  logic       txDataWrEn,
  input  logic [7:0] txDataIn,
  output logic [7:0] rxDataOut,
  input  logic       rxPin,
  output logic       txPin,
  output logic       irq
);

  strobe_t stb;
  logic    rxLine, frame8, rxEn, txDone, rxDone;

  nineuart_ctrl #(.OSR(OSR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .txStart  (txDataWrEn),
    .rxLine   (rxLine),
    .frame8   (frame8),
    .rxEn     (rxEn),
    .stb      (stb)
  );

  nineuart_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .txData    (txDataIn),
    .rxPin     (rxPin),
    .ctrlByte  (ctrlOut),
    .rxData    (rxDataOut),
    .txPin     (txPin),
    .rxLine    (rxLine),
    .frame8    (frame8),
    .rxEn      (rxEn),
    .txDone    (txDone),
    .rxDone    (rxDone)
  );

  assign irq = txDone || rxDone;

endmodule

// File: rtl/nineuart_chk.sv
module nineuart_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] ctrlOut,
  input logic [7:0] rxDataOut,
  input logic       irq
);

  // R11
  irq_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == (ctrlOut[1] || ctrlOut[0]));

  // R4
  txdone_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut[1] && !regWrEn) |=> ctrlOut[1]);

  // R6
  rxdone_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut[0] && !regWrEn) |=> ctrlOut[0]);

  // R9
  rxdata_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxDataOut) |-> ctrlOut[0]);

  // R1
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (ctrlOut[7] == $past(regWrData[7])) &&
                (ctrlOut[5:3] == $past(regWrData[5:3])) && !ctrlOut[6]);

endmodule

bind ninebit_uart nineuart_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .ctrlOut   (ctrlOut),
  .rxDataOut (rxDataOut),
  .irq       (irq)
);

// File: tb/ninebit_uart_test.sv
module ninebit_uart_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] ctrlOut;
  logic       txDataWrEn = 1'b0;
  logic [7:0] txDataIn = '0;
  logic [7:0] rxDataOut;
  logic       rxPin = 1'b1;
  logic       txPin;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam int BITCLK = 64; // 16 ticks, one tick every 4 clocks

  always #10 clk = ~clk; // 50 MHz

  ninebit_uart uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .regWrEn(regWrEn), .regWrData(regWrData), .ctrlOut(ctrlOut),
    .txDataWrEn(txDataWrEn), .txDataIn(txDataIn), .rxDataOut(rxDataOut),
    .rxPin(rxPin), .txPin(txPin), .irq(irq)
  );

  initial begin : tickGen
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % 4;
      baudTick = (cnt == 0);
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic txWrite(input logic [7:0] v);
    @(negedge clk);
    txDataWrEn = 1'b1; txDataIn = v;
    @(negedge clk);
    txDataWrEn = 1'b0;
  endtask

  // waits for a start bit on txPin and returns data (and ninth) bits
  task automatic txCollect(input int nData, output logic [8:0] got, output logic stopBit);
    int guard = 0;
    got = '0;
    while (txPin !== 1'b0 && guard < 300) begin
      waitClk(1); guard++;
    end
    waitClk(BITCLK / 2);
    check(txPin == 1'b0, "R2 start bit", int'(txPin), 0);
    for (int i = 0; i < nData; i++) begin
      waitClk(BITCLK);
      got[i] = txPin;
    end
    waitClk(BITCLK);
    stopBit = txPin;
  endtask

  task automatic sendRx(input logic [7:0] d, input int nData, input logic nine, input logic stopV);
    logic [8:0] bits;
    bits = {nine, d};
    @(negedge clk); rxPin = 1'b0;
    waitClk(BITCLK);
    for (int i = 0; i < nData; i++) begin
      rxPin = bits[i];
      waitClk(BITCLK);
    end
    rxPin = stopV;
    waitClk(BITCLK);
    rxPin = 1'b1;
    waitClk(BITCLK);
  endtask

  task automatic testReset();
    check(ctrlOut == 8'h00, "R1 reset ctrl", ctrlOut, 8'h00);
    check(txPin == 1'b1, "R2 idle line", txPin, 1);
    check(irq == 1'b0, "R11 reset irq", irq, 0);
    check(rxDataOut == 8'h00, "R6 reset data", rxDataOut, 0);
  endtask

  task automatic testRegs();
    regWrite(8'hFF);
    waitClk(1);
    check(ctrlOut == 8'hBF, "R1 write all ones", ctrlOut, 8'hBF);
    check(irq == 1'b1, "R11 irq from written flags", irq, 1);
    regWrite(8'h38);
    waitClk(1);
    check(ctrlOut == 8'h38, "R1 field write", ctrlOut, 8'h38);
    check(irq == 1'b0, "R11 irq cleared", irq, 0);
    regWrite(8'h00);
  endtask

  task automatic testTx9();
    logic [8:0] got; logic stopB;
    regWrite(8'h08);
    txWrite(8'hA5);
    txCollect(9, got, stopB);
    check(got == 9'h1A5, "R2 nine-bit frame A5/1", got, 9'h1A5);
    check(stopB == 1'b1, "R2 stop bit", stopB, 1);
    waitClk(40);
    check(ctrlOut == 8'h0A, "R4 tx done set", ctrlOut, 8'h0A);
    check(irq == 1'b1, "R11 irq on tx done", irq, 1);
    waitClk(200);
    check(ctrlOut[1] == 1'b1, "R4 tx done sticky", ctrlOut[1], 1);
    regWrite(8'h00);
    waitClk(1);
    check(ctrlOut == 8'h00 && irq == 1'b0, "R4 tx done cleared", {irq, ctrlOut}, 0);
    txWrite(8'h3C);
    txCollect(9, got, stopB);
    check(got == 9'h03C, "R2 nine-bit frame 3C/0", got, 9'h03C);
    check(stopB == 1'b1, "R2 stop bit", stopB, 1);
    waitClk(40);
    regWrite(8'h00);
  endtask

  task automatic testTx8();
    logic [8:0] got; logic stopB;
    regWrite(8'h88); // ninth bit set but must not be sent
    txWrite(8'h81);
    txCollect(8, got, stopB);
    check(got[7:0] == 8'h81, "R3 eight-bit data", got[7:0], 8'h81);
    check(stopB == 1'b1, "R3 stop after eighth bit", stopB, 1);
    waitClk(40);
    check(ctrlOut[1] == 1'b1, "R4 tx done eight-bit", ctrlOut[1], 1);
    regWrite(8'h80);
  endtask

  task automatic testTxBusy();
    logic [8:0] got; logic stopB;
    int lows = 0;
    regWrite(8'h80);
    txWrite(8'h55);
    fork
      txCollect(8, got, stopB);
      begin waitClk(150); txWrite(8'hFF); end
    join
    check(got[7:0] == 8'h55 && stopB == 1'b1, "R5 frame unaltered", {stopB, got[7:0]}, 9'h155);
    for (int i = 0; i < 3 * BITCLK; i++) begin
      waitClk(1);
      if (txPin == 1'b0) lows++;
    end
    check(lows == 0, "R5 no second frame", lows, 0);
    check(ctrlOut == 8'h82, "R5 done after ignored write", ctrlOut, 8'h82);
    regWrite(8'h00);
  endtask

  task automatic testRx9();
    regWrite(8'h10);
    sendRx(8'h5A, 9, 1'b1, 1'b1);
    check(rxDataOut == 8'h5A, "R6 rx data", rxDataOut, 8'h5A);
    check(ctrlOut == 8'h15, "R7 ninth bit 1 and rx done", ctrlOut, 8'h15);
    check(irq == 1'b1, "R11 irq on rx done", irq, 1);
    regWrite(8'h10);
    sendRx(8'hC3, 9, 1'b0, 1'b1);
    check(rxDataOut == 8'hC3, "R6 rx data second", rxDataOut, 8'hC3);
    check(ctrlOut == 8'h11, "R7 ninth bit 0", ctrlOut, 8'h11);
  endtask

  task automatic testRx8();
    regWrite(8'h90);
    sendRx(8'h7E, 8, 1'b0, 1'b1);
    check(rxDataOut == 8'h7E, "R8 eight-bit data", rxDataOut, 8'h7E);
    check(ctrlOut == 8'h95, "R8 stop bit 1 captured", ctrlOut, 8'h95);
    regWrite(8'h90);
    sendRx(8'h11, 8, 1'b0, 1'b0);
    check(rxDataOut == 8'h11, "R8 data with bad stop", rxDataOut, 8'h11);
    check(ctrlOut == 8'h91, "R8 stop bit 0 captured", ctrlOut, 8'h91);
    waitClk(BITCLK);
  endtask

  task automatic testRxDisabled();
    regWrite(8'h00);
    sendRx(8'h99, 9, 1'b1, 1'b1);
    check(ctrlOut == 8'h00, "R6 disabled no flag", ctrlOut, 8'h00);
    check(rxDataOut == 8'h11, "R6 disabled data kept", rxDataOut, 8'h11);
    check(irq == 1'b0, "R11 no irq when disabled", irq, 0);
  endtask

  task automatic testAddrFilter();
    regWrite(8'h30);
    sendRx(8'h44, 9, 1'b0, 1'b1);
    check(ctrlOut == 8'h30, "R9 data frame filtered", ctrlOut, 8'h30);
    check(rxDataOut == 8'h11, "R9 filtered data kept", rxDataOut, 8'h11);
    sendRx(8'h66, 9, 1'b1, 1'b1);
    check(ctrlOut == 8'h35, "R9 address frame accepted", ctrlOut, 8'h35);
    check(rxDataOut == 8'h66, "R9 address data", rxDataOut, 8'h66);
  endtask

  task automatic testGlitch();
    regWrite(8'h10);
    @(negedge clk); rxPin = 1'b0;
    waitClk(16);
    rxPin = 1'b1;
    waitClk(12 * BITCLK);
    check(ctrlOut == 8'h10, "R10 glitch rejected", ctrlOut, 8'h10);
    sendRx(8'h2D, 9, 1'b1, 1'b1);
    check(rxDataOut == 8'h2D && ctrlOut == 8'h15, "R10 frame after glitch",
          {rxDataOut, ctrlOut}, 16'h2D15);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    testReset();
    testRegs();
    testTx9();
    testTx8();
    testTxBusy();
    testRx9();
    testRx8();
    testRxDisabled();
    testAddrFilter();
    testGlitch();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule